// File: doc/BRIEF.md
# Auxiliary System Control Register Block

This block holds the small control registers that sit beside a workstation I/O controller. Software reaches them over a simple one-cycle register bus. Each access carries a register select, an offset and a size code. Most registers are plain storage. Four of them have side effects:
- a write to the floppy auxiliary register can fire a terminal-count pulse;
- the power-down register reports a latched power-fail flag and requests power-off;
- a write to the system-control register requests a system reset and leaves a sticky status value;
- the interrupt output follows the power-fail flag, gated by an enable bit.

A power-failing input from the board passes through a two-flop synchronizer. The flag is re-evaluated on each change of the synchronized level. Block reset clears only the control-type registers. The diagnostic, LED and system-control contents survive it, so that software can inspect them after a reset.

Top module: `aux_sysctl_regs`

## Requirements
- R1: A legal write (byte size) to the floppy auxiliary register (select 5) with bit 1 set drives `tcPulse` high for exactly the cycle after the write. Bit 1 is stored as 0, so it always reads back 0. The other bits are stored as written.
- R2: In the power-down register (select 6, byte size), bit 0 (power off) is the only stored writable bit. Bit 5 holds the read-only power-fail flag. All other bits read 0, and a value written to bit 5 is ignored.
- R3: A power-down write with bit 1 (interrupt clear) set clears the power-fail flag. A power-down write without bit 1 leaves the flag unchanged. In both cases written bit 0 becomes the stored power-off bit.
- R4: A power-down write with bit 0 set drives `pwrOffReq` high for the one cycle after the write. A power-down write with bit 0 clear gives no pulse.
- R5: The flag is updated only when the synchronized `pwrFailIn` changes level. At a rising change it is set if configuration bit 3 (interrupt enable) is 1, and otherwise it is left clear. At a falling change it is cleared. The flag changes on the third rising clock edge after the input changes. An input change in the same cycle as an interrupt-clear write takes priority.
- R6: `irqOut` equals the power-fail flag AND configuration bit 3. It follows a configuration write in the cycle after that write.
- R7: A legal word write to system control (select 4, offset 0) with bit 0 set sets the register to 0x02 and drives `sysRstReq` high for one cycle. A write with bit 0 clear has no effect.
- R8: Every register responds only at offset 0. A read at a nonzero offset returns 0, and a write there is ignored.
- R9: Size codes are 0 = byte, 1 = halfword, 2 = word and 3 = reserved. Configuration, diagnostic, modem, floppy auxiliary and power-down take byte accesses only. LED takes halfword accesses only, and system control takes word accesses only. An access of any other size, or to select 7, is ignored on write and reads 0.
- R10: Reset (`rstN` low) clears the configuration, modem, floppy auxiliary and power-down registers, including the flag, and drops all pulse outputs. The diagnostic, LED and system-control registers keep their values.
- R11: The selects are 0 = configuration, 1 = diagnostic, 2 = modem, 3 = LED (16 bit) and 4 = system control. A write to configuration, diagnostic, modem or LED stores the value, and a read returns it on `busRdata` in the same cycle (combinational, zero-extended).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| busValid | input | 1 | Access strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busSel | input | 3 | Register select |
| busSize | input | 2 | Access size code |
| busOffset | input | 2 | Byte offset within the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid while a read is presented |
| pwrFailIn | input | 1 | Asynchronous power-failing indication |
| irqOut | output | 1 | Power-fail interrupt |
| tcPulse | output | 1 | Floppy terminal-count pulse |
| pwrOffReq | output | 1 | Power-off request pulse |
| sysRstReq | output | 1 | System reset request pulse |

## Verification
Each result has its own latency:
- Read data is combinational, so the bench samples it 5 ns after driving a read, in the same cycle.
- The three pulses and every register write become visible from the rising edge that takes the write. The bench drives on a falling edge and checks at the next falling edge. It checks again one cycle later, to confirm that a pulse has dropped.
- A `pwrFailIn` change reaches the flag and `irqOut` at the third rising edge. The bench checks that `irqOut` is still low after the second edge and high after the third.

// File: rtl/aux_regs_pkg.sv
package aux_regs_pkg;

  typedef enum logic [2:0] {
    SEL_CFG  = 3'd0,
    SEL_DIAG = 3'd1,
    SEL_MDM  = 3'd2,
    SEL_LED  = 3'd3,
    SEL_SYS  = 3'd4,
    SEL_AUX1 = 3'd5,
    SEL_PWR  = 3'd6,
    SEL_NONE = 3'd7
  } regSel_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } accSize_e;

  // strobes from control to datapath, one access per cycle
  typedef struct packed {
    logic    wrCfg;
    logic    wrDiag;
    logic    wrMdm;
    logic    wrLed;
    logic    wrSys;
    logic    wrAux1;
    logic    wrPwr;
    logic    rdHit;
    regSel_e rdSel;
  } strobe_t;

  // bit positions other logic depends on
  localparam int TC_BIT      = 1;
  localparam int PWROFF_BIT  = 0;
  localparam int PWRCLR_BIT  = 1;
  localparam int PWRFAIL_BIT = 5;
  localparam int PWREN_BIT   = 3;
  localparam int SYSRST_BIT  = 0;
  localparam int SYSSTAT_BIT = 1;

endpackage

// File: rtl/aux_regs_ctrl.sv
module aux_regs_ctrl
  import aux_regs_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busValid,
  input  logic             busWrite,
  input  logic [2:0]       busSel,
  input  logic [1:0]       busSize,
  input  logic [OFF_W-1:0] busOffset,
  input  logic [1:0]       wrLow,
  output strobe_t          strobes,
  output logic             tcPulse,
  output logic             pwrOffReq,
  output logic             sysRstReq
);

  regSel_e  sel;
  accSize_e size;
  logic     sizeOk;
  logic     legal;

  assign sel  = regSel_e'(busSel);
  assign size = accSize_e'(busSize);

  always_comb begin
    case (sel)
      SEL_CFG, SEL_DIAG, SEL_MDM, SEL_AUX1, SEL_PWR: sizeOk = (size == SZ_BYTE);
      SEL_LED:                                       sizeOk = (size == SZ_HALF);
      SEL_SYS:                                       sizeOk = (size == SZ_WORD);
      default:                                       sizeOk = 1'b0;
    endcase
  end

  assign legal = busValid && (busOffset == '0) && sizeOk;

  always_comb begin
    strobes       = '0;
    strobes.rdSel = sel;
    strobes.rdHit = legal && !busWrite;
    if (legal && busWrite) begin
      case (sel)
        SEL_CFG:  strobes.wrCfg  = 1'b1;
        SEL_DIAG: strobes.wrDiag = 1'b1;
        SEL_MDM:  strobes.wrMdm  = 1'b1;
        SEL_LED:  strobes.wrLed  = 1'b1;
        SEL_SYS:  strobes.wrSys  = 1'b1;
        SEL_AUX1: strobes.wrAux1 = 1'b1;
        SEL_PWR:  strobes.wrPwr  = 1'b1;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tcPulse   <= 1'b0;
      pwrOffReq <= 1'b0;
      sysRstReq <= 1'b0;
    end else begin
      tcPulse   <= strobes.wrAux1 && wrLow[TC_BIT];
      pwrOffReq <= strobes.wrPwr && wrLow[PWROFF_BIT];
      sysRstReq <= strobes.wrSys && wrLow[SYSRST_BIT];
    end
  end

  // R1: a terminal-count pulse only follows a floppy auxiliary write with bit 1
  a_r1_tc_after_write: assert property (@(posedge clk) disable iff (!rstN)
    tcPulse |-> $past(busValid && busWrite && busSel == SEL_AUX1 && wrLow[TC_BIT]));

  // R4: a power-off pulse only follows a power-down write with bit 0
  a_r4_pwroff_after_write: assert property (@(posedge clk) disable iff (!rstN)
    pwrOffReq |-> $past(busValid && busWrite && busSel == SEL_PWR && wrLow[PWROFF_BIT]));

  // R7: a reset request only follows a word write at offset 0
  a_r7_rst_after_write: assert property (@(posedge clk) disable iff (!rstN)
    sysRstReq |-> $past(busValid && busWrite && busSel == SEL_SYS &&
                        busSize == SZ_WORD && busOffset == '0));

  // R9: no write strobe for an access of the wrong size
  a_r9_size_gate: assert property (@(posedge clk) disable iff (!rstN)
    (busSize == SZ_RSVD) |-> !(strobes.wrCfg || strobes.wrDiag || strobes.wrMdm ||
      strobes.wrLed || strobes.wrSys || strobes.wrAux1 || strobes.wrPwr || strobes.rdHit));

endmodule

// File: rtl/aux_regs_data.sv
module aux_regs_data
  import aux_regs_pkg::*;
#(
  parameter int BUS_W       = 32,
  parameter int REG_W       = 8,
  parameter int LED_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobes,
  input  logic [LED_W-1:0] wrData,
  input  logic             pwrFailIn,
  output logic [BUS_W-1:0] rdData,
  output logic             irqOut
);

  localparam logic [REG_W-1:0] TC_MASK  = REG_W'(1) << TC_BIT;
  localparam logic [REG_W-1:0] SYS_STAT = REG_W'(1) << SYSSTAT_BIT;

  logic [REG_W-1:0]       cfgQ, diagQ, mdmQ, aux1Q, sysQ;
  logic [LED_W-1:0]       ledQ;
  logic                   pwrOffQ, failFlag;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   failSync, failSyncD, failEvt;
  logic [REG_W-1:0]       pwrView;

  assign failSync = syncQ[SYNC_STAGES-1];
  assign failEvt  = failSync ^ failSyncD;

  // registers cleared by block reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ      <= '0;
      mdmQ      <= '0;
      aux1Q     <= '0;
      pwrOffQ   <= 1'b0;
      failFlag  <= 1'b0;
      syncQ     <= '0;
      failSyncD <= 1'b0;
    end else begin
      syncQ     <= {syncQ[SYNC_STAGES-2:0], pwrFailIn};
      failSyncD <= failSync;
      if (strobes.wrCfg)  cfgQ  <= wrData[REG_W-1:0];
      if (strobes.wrMdm)  mdmQ  <= wrData[REG_W-1:0];
      if (strobes.wrAux1) aux1Q <= wrData[REG_W-1:0] & ~TC_MASK;
      if (strobes.wrPwr)  pwrOffQ <= wrData[PWROFF_BIT];
      if (failEvt)
        failFlag <= failSync && cfgQ[PWREN_BIT];
      else if (strobes.wrPwr && wrData[PWRCLR_BIT])
        failFlag <= 1'b0;
    end
  end

  // registers that survive block reset
  always_ff @(posedge clk) begin
    if (strobes.wrDiag) diagQ <= wrData[REG_W-1:0];
    if (strobes.wrLed)  ledQ  <= wrData;
    if (strobes.wrSys && wrData[SYSRST_BIT]) sysQ <= SYS_STAT;
  end

  assign irqOut = failFlag && cfgQ[PWREN_BIT];

  always_comb begin
    pwrView              = '0;
    pwrView[PWROFF_BIT]  = pwrOffQ;
    pwrView[PWRFAIL_BIT] = failFlag;
  end

  always_comb begin
    rdData = '0;
    if (strobes.rdHit) begin
      case (strobes.rdSel)
        SEL_CFG:  rdData = BUS_W'(cfgQ);
        SEL_DIAG: rdData = BUS_W'(diagQ);
        SEL_MDM:  rdData = BUS_W'(mdmQ);
        SEL_LED:  rdData = BUS_W'(ledQ);
        SEL_SYS:  rdData = BUS_W'(sysQ);
        SEL_AUX1: rdData = BUS_W'(aux1Q);
        SEL_PWR:  rdData = BUS_W'(pwrView);
        default:  rdData = '0;
      endcase
    end
  end

  // R3: a clear write with no input change leaves the flag low
  a_r3_clear_flag: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrPwr && wrData[PWRCLR_BIT] && !failEvt) |=> !failFlag);

  // R5: the flag only rises while the interrupt enable is set
  a_r5_flag_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(failFlag) |-> $past(cfgQ[PWREN_BIT]));

  // R5: the flag only changes on a synchronized input change or a power-down write
  a_r5_flag_source: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(failFlag) |-> $past(failEvt || strobes.wrPwr));

  // R7: a reset-request write leaves the status value
  a_r7_sticky_status: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrSys && wrData[SYSRST_BIT]) |=> (sysQ == SYS_STAT));

endmodule

// File: rtl/aux_sysctl_regs.sv
module aux_sysctl_regs
  import aux_regs_pkg::*;
#(
  parameter int BUS_W       = 32,
  parameter int OFF_W       = 2,
  parameter int REG_W       = 8,
  parameter int LED_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busValid,
  input  logic             busWrite,
  input  logic [2:0]       busSel,
  input  logic [1:0]       busSize,
  input  logic [OFF_W-1:0] busOffset,
  input  logic [BUS_W-1:0] busWdata,
  output logic [BUS_W-1:0] busRdata,
  input  logic             pwrFailIn,
  output logic             irqOut,
  output logic             tcPulse,
  output logic             pwrOffReq,
  output logic             sysRstReq
);

  strobe_t strobes;
  logic    unusedHi;

  assign unusedHi = ^busWdata[BUS_W-1:LED_W];

  aux_regs_ctrl #(.OFF_W(OFF_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busValid  (busValid),
    .busWrite  (busWrite),
    .busSel    (busSel),
    .busSize   (busSize),
    .busOffset (busOffset),
    .wrLow     (busWdata[1:0]),
    .strobes   (strobes),
    .tcPulse   (tcPulse),
    .pwrOffReq (pwrOffReq),
    .sysRstReq (sysRstReq)
  );

  aux_regs_data #(
    .BUS_W       (BUS_W),
    .REG_W       (REG_W),
    .LED_W       (LED_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrData    (busWdata[LED_W-1:0]),
    .pwrFailIn (pwrFailIn),
    .rdData    (busRdata),
    .irqOut    (irqOut)
  );

endmodule

// File: tb/test_aux_sysctl_regs.sv
module test_aux_sysctl_regs;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [2:0]  busSel = '0;
  logic [1:0]  busSize = '0;
  logic [1:0]  busOffset = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        pwrFailIn = 1'b0;
  logic        irqOut, tcPulse, pwrOffReq, sysRstReq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  aux_sysctl_regs i_aux_sysctl_regs (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busSel(busSel), .busSize(busSize), .busOffset(busOffset),
    .busWdata(busWdata), .busRdata(busRdata), .pwrFailIn(pwrFailIn),
    .irqOut(irqOut), .tcPulse(tcPulse), .pwrOffReq(pwrOffReq), .sysRstReq(sysRstReq)
  );

  localparam logic [2:0] CFG = 0, DIAG = 1, MDM = 2, LED = 3, SYS = 4, AUX1 = 5, PWR = 6, NONE = 7;
  localparam logic [1:0] B = 0, H = 1, W = 2;

  typedef struct packed {
    logic        wr;
    logic [2:0]  sel;
    logic [1:0]  size;
    logic [1:0]  off;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{1'b1, CFG,  B, 2'd0, 32'hA5,       32'h0},
    '{1'b0, CFG,  B, 2'd0, 32'h0,        32'hA5},   // R11
    '{1'b1, DIAG, B, 2'd0, 32'h3C,       32'h0},
    '{1'b0, DIAG, B, 2'd0, 32'h0,        32'h3C},   // R11
    '{1'b1, MDM,  B, 2'd0, 32'h81,       32'h0},
    '{1'b0, MDM,  B, 2'd0, 32'h0,        32'h81},   // R11
    '{1'b1, LED,  H, 2'd0, 32'hBEEF,     32'h0},
    '{1'b0, LED,  H, 2'd0, 32'h0,        32'hBEEF}, // R11
    '{1'b1, LED,  H, 2'd2, 32'h1234,     32'h0},
    '{1'b0, LED,  H, 2'd2, 32'h0,        32'h0},    // R8
    '{1'b0, LED,  H, 2'd0, 32'h0,        32'hBEEF}, // R8 write ignored
    '{1'b1, DIAG, H, 2'd0, 32'hFF,       32'h0},
    '{1'b0, DIAG, B, 2'd0, 32'h0,        32'h3C},   // R9 write ignored
    '{1'b0, DIAG, W, 2'd0, 32'h0,        32'h0},    // R9 read zero
    '{1'b1, AUX1, B, 2'd0, 32'h57,       32'h0},
    '{1'b0, AUX1, B, 2'd0, 32'h0,        32'h55},   // R1
    '{1'b1, SYS,  W, 2'd0, 32'h1,        32'h0},
    '{1'b0, SYS,  W, 2'd0, 32'h0,        32'h2},    // R7
    '{1'b1, SYS,  W, 2'd0, 32'hFFFFFFFE, 32'h0},
    '{1'b0, SYS,  W, 2'd0, 32'h0,        32'h2},    // R7 no effect
    '{1'b0, SYS,  W, 2'd1, 32'h0,        32'h0},    // R8
    '{1'b1, PWR,  B, 2'd0, 32'hFC,       32'h0},
    '{1'b0, PWR,  B, 2'd0, 32'h0,        32'h0},    // R2
    '{1'b0, NONE, B, 2'd0, 32'h0,        32'h0}     // R9
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [2:0] sel, input logic [1:0] size,
                         input logic [1:0] off, input logic [31:0] data);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busSel = sel; busSize = size;
    busOffset = off; busWdata = data;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic doRead(input logic [2:0] sel, input logic [1:0] size,
                        input logic [1:0] off, output logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busSel = sel; busSize = size; busOffset = off;
    #5 d = busRdata;
    busValid = 1'b0;
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    logic [31:0] d;
    applyReset();

    // R10 reset state
    doRead(CFG, B, 0, d);  check("R10 cfg after reset", d, 0);
    doRead(MDM, B, 0, d);  check("R10 modem after reset", d, 0);
    doRead(AUX1, B, 0, d); check("R10 aux after reset", d, 0);
    doRead(PWR, B, 0, d);  check("R10 power after reset", d, 0);
    check("R10 outputs after reset", {28'd0, irqOut, tcPulse, pwrOffReq, sysRstReq}, 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) doWrite(VEC[i].sel, VEC[i].size, VEC[i].off, VEC[i].data);
      else begin
        doRead(VEC[i].sel, VEC[i].size, VEC[i].off, d);
        check($sformatf("table entry %0d", i), d, VEC[i].exp);
      end
    end

    // R1 pulse
    doWrite(AUX1, B, 0, 32'h02);
    #1 check("R1 tc pulse high", {31'd0, tcPulse}, 1);
    @(negedge clk); #1 check("R1 tc pulse low", {31'd0, tcPulse}, 0);
    doRead(AUX1, B, 0, d); check("R1 bit1 reads 0", d, 0);

    // R7 reset request pulse
    doWrite(SYS, W, 0, 32'h1);
    #1 check("R7 reset request high", {31'd0, sysRstReq}, 1);
    @(negedge clk); #1 check("R7 reset request low", {31'd0, sysRstReq}, 0);

    // R4 power off
    doWrite(PWR, B, 0, 32'h01);
    #1 check("R4 power-off pulse", {31'd0, pwrOffReq}, 1);
    @(negedge clk); #1 check("R4 power-off drops", {31'd0, pwrOffReq}, 0);
    doRead(PWR, B, 0, d); check("R2 power-off bit stored", d, 32'h01);
    doWrite(PWR, B, 0, 32'h00);
    #1 check("R4 no pulse without bit0", {31'd0, pwrOffReq}, 0);

    // R5 latency, R6 interrupt
    doWrite(CFG, B, 0, 32'h08);
    pwrFailIn = 1'b1;
    waitCycles(2); #1 check("R5 flag not yet after 2 edges", {31'd0, irqOut}, 0);
    waitCycles(1); #1 check("R5 R6 irq after 3 edges", {31'd0, irqOut}, 1);
    doRead(PWR, B, 0, d); check("R5 flag set", d, 32'h20);
    doWrite(CFG, B, 0, 32'h00);
    #1 check("R6 irq follows enable off", {31'd0, irqOut}, 0);
    doRead(PWR, B, 0, d); check("R6 flag kept with enable off", d, 32'h20);
    doWrite(CFG, B, 0, 32'h08);
    #1 check("R6 irq follows enable on", {31'd0, irqOut}, 1);

    // R3 preserve and clear
    doWrite(PWR, B, 0, 32'h20);
    doRead(PWR, B, 0, d); check("R3 flag preserved", d, 32'h20);
    doWrite(PWR, B, 0, 32'h02);
    #1 check("R3 irq cleared", {31'd0, irqOut}, 0);
    waitCycles(5);
    doRead(PWR, B, 0, d); check("R3 flag stays clear", d, 0);

    // R5 falling change clears
    pwrFailIn = 1'b0; waitCycles(4);
    pwrFailIn = 1'b1; waitCycles(4);
    doRead(PWR, B, 0, d); check("R5 rearmed", d, 32'h20);
    pwrFailIn = 1'b0; waitCycles(4);
    doRead(PWR, B, 0, d); check("R5 cleared by input low", d, 0);

    // R5 gating
    doWrite(CFG, B, 0, 32'h00);
    pwrFailIn = 1'b1; waitCycles(4);
    doRead(PWR, B, 0, d); check("R5 enable gates flag", d, 0);
    doWrite(CFG, B, 0, 32'h08);
    #1 check("R6 no irq without flag", {31'd0, irqOut}, 0);

    // R3 clear with power off
    pwrFailIn = 1'b0; waitCycles(4);
    pwrFailIn = 1'b1; waitCycles(4);
    doWrite(PWR, B, 0, 32'h23);
    #1 check("R4 pulse with clear", {31'd0, pwrOffReq}, 1);
    doRead(PWR, B, 0, d); check("R3 clear keeps bit0", d, 32'h01);

    // R10 selective reset
    doWrite(DIAG, B, 0, 32'h77);
    doWrite(LED, H, 0, 32'h5A5A);
    doWrite(AUX1, B, 0, 32'h0C);
    applyReset();
    waitCycles(4);
    doRead(CFG, B, 0, d);  check("R10 cfg cleared", d, 0);
    doRead(AUX1, B, 0, d); check("R10 aux cleared", d, 0);
    doRead(PWR, B, 0, d);  check("R10 power cleared", d, 0);
    doRead(DIAG, B, 0, d); check("R10 diag kept", d, 32'h77);
    doRead(LED, H, 0, d);  check("R10 led kept", d, 32'h5A5A);
    doRead(SYS, W, 0, d);  check("R10 sysctl kept", d, 32'h2);
    check("R10 irq low", {31'd0, irqOut}, 0);

    finishRun();
  end

endmodule